// File: doc/BRIEF.md
# Isochronous-IN Packet Assembler

This block assembles the payload of one isochronous-IN packet for a USB-attached ISDN line controller. Three receive channels feed it: a signalling channel (D) and two bearer channels (B1, B2). Each has its own receive FIFO. When a packet is requested, the block emits a lead status byte and then one segment per channel in a fixed order. A segment is a header byte followed by a run of data bytes taken from that channel's FIFO. The header packs the transmit-side status flags, the sticky receive-overflow flag and the segment's data length.

Receive FIFOs start disabled. Each one is switched on by its own enable command. A FIFO that overflows empties itself, switches off and raises its overflow flag. It then contributes empty segments until software enables it again. A separate sticky flag records a CRC error on the most recent isochronous-OUT packet, and it is reported in the lead byte. The output is a byte stream, one byte per clock, marked with start and end strobes.

Top module: `isoin_pkt_asm`

## Requirements
- R1: After reset all three receive FIFOs are disabled, all stream outputs and `pkt_busy` are low, and a request yields a packet of exactly four bytes (lead byte and three headers) with every length field zero.
- R2: While a channel's FIFO is disabled, writes to it are dropped, so its segment has length 0 and carries no data bytes.
- R3: A FIFO is enabled only by a one-cycle pulse on its bit of `rx_en_cmd`. The pulse also empties the FIFO and clears its overflow flag. A write arriving in the same cycle as the pulse is dropped.
- R4: A packet is the lead byte, then the D header and D data, then the B1 header and B1 data, then the B2 header and B2 data. The bytes come on consecutive cycles with `pkt_sop` on the first and `pkt_eop` on the last, and at least one idle cycle follows every packet.
- R5: The lead byte carries the isochronous-OUT error flag in bit 7 and zeros in bits 6..0.
- R6: A pulse on `out_crc_err` sets the error flag. The flag stays set until a pulse on `isoe_clear`. When both pulses arrive in the same cycle, the flag is set.
- R7: The D header is {xfr, xcol, xdov, xdun, rdov, len[2:0]} from bit 7 down to bit 0, where the four transmit flags are `d_tx_stat[3:0]` in that order.
- R8: A B1 or B2 header is {xfr, xdov, xdun, rdov, len[3:0]} from bit 7 down to bit 0, where the three transmit flags are `bN_tx_stat[2:0]` in that order.
- R9: Each segment length is the smaller of the FIFO fill level and the field maximum (7 for D, 15 for B1 and B2). Exactly that many bytes are taken from the head of the FIFO in write order, and any bytes beyond that stay for later packets.
- R10: A write to an enabled FIFO that already holds its full depth, with no read in the same cycle, empties and disables the FIFO and sets its overflow flag. The flag stays set until the next enable pulse.
- R11: Transmit flags, the error flag, overflow flags and lengths are all captured in the cycle the request is accepted. Changes to them while the packet is being sent do not alter that packet.
- R12: A request raised while `pkt_busy` is high is ignored and produces no further packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_wr_en | input | 3 | Per-channel write strobe (bit 0 D, bit 1 B1, bit 2 B2) |
| rx_wr_data | input | 24 | Channel bytes: [7:0] D, [15:8] B1, [23:16] B2 |
| rx_en_cmd | input | 3 | Per-channel receive-enable pulse |
| out_crc_err | input | 1 | Pulse: isochronous-OUT packet had a CRC error |
| isoe_clear | input | 1 | Pulse: clear the isochronous-OUT error flag |
| d_tx_stat | input | 4 | D transmit flags {xfr, xcol, xdov, xdun} |
| b1_tx_stat | input | 3 | B1 transmit flags {xfr, xdov, xdun} |
| b2_tx_stat | input | 3 | B2 transmit flags {xfr, xdov, xdun} |
| pkt_req | input | 1 | Request one packet; accepted when not busy |
| pkt_valid | output | 1 | Output byte valid |
| pkt_sop | output | 1 | First byte of packet |
| pkt_eop | output | 1 | Last byte of packet |
| pkt_data | output | 8 | Packet byte |
| pkt_busy | output | 1 | A packet is being assembled |

## Verification
The bench builds the block with a D FIFO depth of 10 and a B FIFO depth of 20. These are just above the length-field limits of 7 and 15. With these depths, a fill sweep from 0 to 20 bytes reaches every uncapped length, the capped case, and drains that take several packets. An overflow is forced with only 11 or 21 writes. Stepping the transmit flags with the sweep index covers every D flag combination and every B flag combination. The lead-byte error flag, capture during an active packet, and ignored requests each get dedicated runs.

// File: rtl/isoin_pkg.sv
package isoin_pkg;

  localparam int NCH       = 3;   // D, B1, B2 in emission order
  localparam int LENW      = 4;   // widest segment length field
  localparam int D_LEN_MAX = 7;
  localparam int B_LEN_MAX = 15;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_HDR,
    SQ_DATA
  } seq_state_e;

  typedef struct packed {
    logic xfr;
    logic xcol;
    logic xdov;
    logic xdun;
  } d_tx_t;

  typedef struct packed {
    logic xfr;
    logic xdov;
    logic xdun;
  } b_tx_t;

  function automatic logic [7:0] d_hdr(d_tx_t t, logic rdov, logic [2:0] len);
    return {t, rdov, len};
  endfunction

  function automatic logic [7:0] b_hdr(b_tx_t t, logic rdov, logic [3:0] len);
    return {t, rdov, len};
  endfunction

  function automatic logic [7:0] lead_byte(logic err);
    return {err, 7'b0};
  endfunction

endpackage

// File: rtl/isoin_rx_fifo.sv
module isoin_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          en_cmd,
  input  logic          pop,
  output logic [CW-1:0] fill,
  output logic [W-1:0]  rd_q,
  output logic          empty,
  output logic          full,
  output logic          enabled,
  output logic          rdov
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          en_q, rdov_q;

  logic do_pop, wr_try, do_wr, ovf, flush;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign wr_try  = en_q && wr_en && !en_cmd;
  assign do_wr   = wr_try && (!full || do_pop);
  assign ovf     = wr_try && full && !do_pop;
  assign flush   = en_cmd || ovf;

  // storage: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      en_q   <= 1'b0;
      rdov_q <= 1'b0;
    end else begin
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
        cnt  <= '0;
      end else begin
        if (do_wr)  wptr <= step(wptr);
        if (do_pop) rptr <= step(rptr);
        case ({do_wr, do_pop})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
      if (en_cmd) begin
        en_q   <= 1'b1;
        rdov_q <= 1'b0;
      end else if (ovf) begin
        en_q   <= 1'b0;
        rdov_q <= 1'b1;
      end
    end
  end

  assign fill    = cnt;
  assign enabled = en_q;
  assign rdov    = rdov_q;

endmodule

// File: rtl/isoin_seq.sv
module isoin_seq
  import isoin_pkg::*;
#(
  parameter int NSEG = NCH,
  parameter int LW   = LENW,
  localparam int CHW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [7:0]        lead_in,
  input  logic [NSEG*8-1:0] hdr_in,
  input  logic [NSEG*LW-1:0] len_in,
  output logic              busy,
  output logic [NSEG-1:0]   pop,
  output logic              s1_valid,
  output logic              s1_sop,
  output logic              s1_eop,
  output logic              s1_data,
  output logic [CHW-1:0]    s1_ch,
  output logic [7:0]        s1_byte
);

  seq_state_e     state, st_n;
  logic [CHW-1:0] ch_q, ch_n;
  logic [LW-1:0]  cnt_q, cnt_n;
  logic [7:0]     lead_q;
  logic [7:0]     hdr_q [NSEG];
  logic [LW-1:0]  len_q [NSEG];

  logic       load, emit, e_sop, e_eop, e_data, last_ch;
  logic [7:0] e_byte;

  always_comb begin
    st_n    = state;
    ch_n    = ch_q;
    cnt_n   = cnt_q;
    load    = 1'b0;
    emit    = 1'b0;
    e_sop   = 1'b0;
    e_eop   = 1'b0;
    e_data  = 1'b0;
    e_byte  = 8'h00;
    pop     = '0;
    last_ch = (ch_q == CHW'(NSEG - 1));
    case (state)
      SQ_IDLE: begin
        if (req) begin
          load = 1'b1;
          st_n = SQ_LEAD;
        end
      end
      SQ_LEAD: begin
        emit   = 1'b1;
        e_sop  = 1'b1;
        e_byte = lead_q;
        ch_n   = '0;
        st_n   = SQ_HDR;
      end
      SQ_HDR: begin
        emit   = 1'b1;
        e_byte = hdr_q[ch_q];
        if (len_q[ch_q] != '0) begin
          cnt_n = len_q[ch_q];
          st_n  = SQ_DATA;
        end else if (last_ch) begin
          e_eop = 1'b1;
          st_n  = SQ_IDLE;
        end else begin
          ch_n = ch_q + 1'b1;
        end
      end
      SQ_DATA: begin
        emit      = 1'b1;
        e_data    = 1'b1;
        pop[ch_q] = 1'b1;
        cnt_n     = cnt_q - 1'b1;
        if (cnt_q == LW'(1)) begin
          if (last_ch) begin
            e_eop = 1'b1;
            st_n  = SQ_IDLE;
          end else begin
            ch_n = ch_q + 1'b1;
            st_n = SQ_HDR;
          end
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      ch_q  <= '0;
      cnt_q <= '0;
    end else begin
      state <= st_n;
      ch_q  <= ch_n;
      cnt_q <= cnt_n;
    end
  end

  // snapshot of everything the packet reports
  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q <= 8'h00;
      for (int c = 0; c < NSEG; c++) begin
        hdr_q[c] <= 8'h00;
        len_q[c] <= '0;
      end
    end else if (load) begin
      lead_q <= lead_in;
      for (int c = 0; c < NSEG; c++) begin
        hdr_q[c] <= hdr_in[c*8 +: 8];
        len_q[c] <= len_in[c*LW +: LW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sop   <= 1'b0;
      s1_eop   <= 1'b0;
      s1_data  <= 1'b0;
      s1_ch    <= '0;
      s1_byte  <= 8'h00;
    end else begin
      s1_valid <= emit;
      s1_sop   <= e_sop;
      s1_eop   <= e_eop;
      s1_data  <= e_data;
      s1_ch    <= ch_q;
      s1_byte  <= e_byte;
    end
  end

  assign busy = (state != SQ_IDLE);

endmodule

// File: rtl/isoin_pkt_asm.sv
module isoin_pkt_asm
  import isoin_pkg::*;
#(
  parameter int D_DEPTH = 16,
  parameter int B_DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  rx_wr_en,
  input  logic [23:0] rx_wr_data,
  input  logic [2:0]  rx_en_cmd,
  input  logic        out_crc_err,
  input  logic        isoe_clear,
  input  logic [3:0]  d_tx_stat,
  input  logic [2:0]  b1_tx_stat,
  input  logic [2:0]  b2_tx_stat,
  input  logic        pkt_req,
  output logic        pkt_valid,
  output logic        pkt_sop,
  output logic        pkt_eop,
  output logic [7:0]  pkt_data,
  output logic        pkt_busy
);

  localparam int LW  = LENW;
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0] fifo_en, fifo_rdov, fifo_full, fifo_empty, fifo_pop;
  logic [7:0]     fifo_rd   [NCH];
  logic [LW-1:0]  len_avail [NCH];
  logic           isoe_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int DEP = (c == 0) ? D_DEPTH : B_DEPTH;
    localparam int CAP = (c == 0) ? D_LEN_MAX : B_LEN_MAX;
    localparam int CW  = $clog2(DEP + 1);
    logic [CW-1:0] fill;

    isoin_rx_fifo #(.DEPTH(DEP), .W(8)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (rx_wr_en[c]),
      .wr_data (rx_wr_data[c*8 +: 8]),
      .en_cmd  (rx_en_cmd[c]),
      .pop     (fifo_pop[c]),
      .fill    (fill),
      .rd_q    (fifo_rd[c]),
      .empty   (fifo_empty[c]),
      .full    (fifo_full[c]),
      .enabled (fifo_en[c]),
      .rdov    (fifo_rdov[c])
    );

    assign len_avail[c] = (int'(fill) > CAP) ? LW'(CAP) : LW'(fill);
  end

  // sticky isochronous-OUT error, set wins over clear
  always_ff @(posedge clk) begin
    if (rst)              isoe_q <= 1'b0;
    else if (out_crc_err) isoe_q <= 1'b1;
    else if (isoe_clear)  isoe_q <= 1'b0;
  end

  logic [NCH*8-1:0]  hdr_bus;
  logic [NCH*LW-1:0] len_bus;

  always_comb begin
    hdr_bus[7:0]   = d_hdr(d_tx_t'(d_tx_stat),  fifo_rdov[0], len_avail[0][2:0]);
    hdr_bus[15:8]  = b_hdr(b_tx_t'(b1_tx_stat), fifo_rdov[1], len_avail[1]);
    hdr_bus[23:16] = b_hdr(b_tx_t'(b2_tx_stat), fifo_rdov[2], len_avail[2]);
    for (int c = 0; c < NCH; c++) len_bus[c*LW +: LW] = len_avail[c];
  end

  logic           s1_valid, s1_sop, s1_eop, s1_data;
  logic [CHW-1:0] s1_ch;
  logic [7:0]     s1_byte;
  logic           zero_q;

  isoin_seq #(.NSEG(NCH), .LW(LW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (pkt_req),
    .lead_in  (lead_byte(isoe_q)),
    .hdr_in   (hdr_bus),
    .len_in   (len_bus),
    .busy     (pkt_busy),
    .pop      (fifo_pop),
    .s1_valid (s1_valid),
    .s1_sop   (s1_sop),
    .s1_eop   (s1_eop),
    .s1_data  (s1_data),
    .s1_ch    (s1_ch),
    .s1_byte  (s1_byte)
  );

  // a byte promised in a header but lost to a flush is sent as zero
  always_ff @(posedge clk) begin
    if (rst) zero_q <= 1'b0;
    else     zero_q <= |(fifo_pop & fifo_empty);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid <= 1'b0;
      pkt_sop   <= 1'b0;
      pkt_eop   <= 1'b0;
      pkt_data  <= 8'h00;
    end else begin
      pkt_valid <= s1_valid;
      pkt_sop   <= s1_sop;
      pkt_eop   <= s1_eop;
      if (s1_data) pkt_data <= zero_q ? 8'h00 : fifo_rd[s1_ch];
      else         pkt_data <= s1_byte;
    end
  end

endmodule

// File: rtl/isoin_pkt_asm_chk.sv
module isoin_pkt_asm_chk (
  input logic       clk,
  input logic       rst,
  input logic       pkt_valid,
  input logic       pkt_sop,
  input logic       pkt_eop,
  input logic [2:0] rx_wr_en,
  input logic [2:0] rx_en_cmd,
  input logic [2:0] fifo_en,
  input logic [2:0] fifo_rdov,
  input logic [2:0] fifo_full,
  input logic [2:0] fifo_empty,
  input logic [2:0] fifo_pop,
  input logic       isoe_q,
  input logic       isoe_clear,
  input logic       out_crc_err
);

  a_r1_reset_disabled: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fifo_en == 3'b000));

  a_r4_sop_valid: assert property (@(posedge clk) disable iff (rst)
    pkt_sop |-> (pkt_valid && !pkt_eop));

  a_r4_contiguous: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_eop) |=> pkt_valid);

  a_r4_gap_after_end: assert property (@(posedge clk) disable iff (rst)
    pkt_eop |=> !pkt_valid);

  a_r6_isoe_set: assert property (@(posedge clk) disable iff (rst)
    out_crc_err |=> isoe_q);

  a_r6_isoe_hold: assert property (@(posedge clk) disable iff (rst)
    (isoe_q && !isoe_clear) |=> isoe_q);

  for (genvar c = 0; c < 3; c++) begin : g_ch
    a_r2_disabled_empty: assert property (@(posedge clk) disable iff (rst)
      !fifo_en[c] |-> fifo_empty[c]);

    a_r3_enable_only_cmd: assert property (@(posedge clk) disable iff (rst)
      (!fifo_en[c] && !rx_en_cmd[c]) |=> !fifo_en[c]);

    a_r3_enable_clears: assert property (@(posedge clk) disable iff (rst)
      rx_en_cmd[c] |=> (fifo_en[c] && !fifo_rdov[c] && fifo_empty[c]));

    a_r10_overflow: assert property (@(posedge clk) disable iff (rst)
      (fifo_en[c] && rx_wr_en[c] && !rx_en_cmd[c] && fifo_full[c] && !fifo_pop[c])
      |=> (!fifo_en[c] && fifo_rdov[c] && fifo_empty[c]));

    a_r10_rdov_sticky: assert property (@(posedge clk) disable iff (rst)
      (fifo_rdov[c] && !rx_en_cmd[c]) |=> fifo_rdov[c]);
  end

endmodule

bind isoin_pkt_asm isoin_pkt_asm_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pkt_valid   (pkt_valid),
  .pkt_sop     (pkt_sop),
  .pkt_eop     (pkt_eop),
  .rx_wr_en    (rx_wr_en),
  .rx_en_cmd   (rx_en_cmd),
  .fifo_en     (fifo_en),
  .fifo_rdov   (fifo_rdov),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop),
  .isoe_q      (isoe_q),
  .isoe_clear  (isoe_clear),
  .out_crc_err (out_crc_err)
);

// File: tb/sim_isoin_pkt_asm.sv
module sim_isoin_pkt_asm;

  localparam int CLK_PERIOD = 10;
  localparam int DD = 10;
  localparam int BD = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  rx_wr_en = '0;
  logic [23:0] rx_wr_data = '0;
  logic [2:0]  rx_en_cmd = '0;
  logic        out_crc_err = 1'b0;
  logic        isoe_clear = 1'b0;
  logic [3:0]  d_tx_stat = '0;
  logic [2:0]  b1_tx_stat = '0;
  logic [2:0]  b2_tx_stat = '0;
  logic        pkt_req = 1'b0;
  logic        pkt_valid, pkt_sop, pkt_eop, pkt_busy;
  logic [7:0]  pkt_data;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] mq0[$], mq1[$], mq2[$], exp_q[$], got_q[$];
  bit m_en [3];
  bit m_rdov [3];
  bit m_isoe;

  always #(CLK_PERIOD/2) clk = ~clk;

  isoin_pkt_asm #(.D_DEPTH(DD), .B_DEPTH(BD)) u0 (
    .clk(clk), .rst(rst), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
    .rx_en_cmd(rx_en_cmd), .out_crc_err(out_crc_err), .isoe_clear(isoe_clear),
    .d_tx_stat(d_tx_stat), .b1_tx_stat(b1_tx_stat), .b2_tx_stat(b2_tx_stat),
    .pkt_req(pkt_req), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .pkt_data(pkt_data), .pkt_busy(pkt_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int depth(int c); return (c == 0) ? DD : BD; endfunction
  function automatic int cap(int c);   return (c == 0) ? 7 : 15;  endfunction

  function automatic int q_size(int c);
    case (c)
      0:       return mq0.size();
      1:       return mq1.size();
      default: return mq2.size();
    endcase
  endfunction

  function automatic void q_push(int c, logic [7:0] v);
    case (c)
      0:       mq0.push_back(v);
      1:       mq1.push_back(v);
      default: mq2.push_back(v);
    endcase
  endfunction

  function automatic logic [7:0] q_pop(int c);
    case (c)
      0:       return mq0.pop_front();
      1:       return mq1.pop_front();
      default: return mq2.pop_front();
    endcase
  endfunction

  function automatic void q_clear(int c);
    case (c)
      0:       mq0.delete();
      1:       mq1.delete();
      default: mq2.delete();
    endcase
  endfunction

  task automatic write_byte(int c, logic [7:0] v);
    rx_wr_en[c] = 1'b1;
    rx_wr_data[c*8 +: 8] = v;
    @(negedge clk);
    rx_wr_en[c] = 1'b0;
    if (m_en[c]) begin
      if (q_size(c) == depth(c)) begin
        q_clear(c);
        m_en[c] = 1'b0;
        m_rdov[c] = 1'b1;
      end else begin
        q_push(c, v);
      end
    end
  endtask

  task automatic enable_ch(int c);
    rx_en_cmd[c] = 1'b1;
    @(negedge clk);
    rx_en_cmd[c] = 1'b0;
    m_en[c] = 1'b1;
    m_rdov[c] = 1'b0;
    q_clear(c);
  endtask

  task automatic build_exp();
    int len;
    exp_q.delete();
    exp_q.push_back({m_isoe, 7'b0});
    for (int c = 0; c < 3; c++) begin
      len = (q_size(c) > cap(c)) ? cap(c) : q_size(c);
      case (c)
        0:       exp_q.push_back({d_tx_stat,  m_rdov[0], 3'(len)});
        1:       exp_q.push_back({b1_tx_stat, m_rdov[1], 4'(len)});
        default: exp_q.push_back({b2_tx_stat, m_rdov[2], 4'(len)});
      endcase
      for (int k = 0; k < len; k++) exp_q.push_back(q_pop(c));
    end
  endtask

  task automatic get_packet(string tag);
    int  waitc;
    bit  done;
    int  n;
    build_exp();
    got_q.delete();
    pkt_req = 1'b1;
    @(negedge clk);
    pkt_req = 1'b0;
    done = 1'b0;
    waitc = 0;
    while (!done && waitc < 200) begin
      if (pkt_valid) begin
        chk(pkt_sop == (got_q.size() == 0), {tag, " R4 sop marker"}, int'(pkt_sop),
            int'(got_q.size() == 0));
        got_q.push_back(pkt_data);
        if (pkt_eop) done = 1'b1;
      end
      if (!done) begin
        @(negedge clk);
        waitc++;
      end
    end
    chk(done, {tag, " R4 packet end"}, int'(done), 1);
    chk(got_q.size() == exp_q.size(), {tag, " R4 length"}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int k = 0; k < n; k++)
      chk(got_q[k] == exp_q[k], $sformatf("%s byte %0d", tag, k), int'(got_q[k]), int'(exp_q[k]));
    @(negedge clk);
    chk(!pkt_valid, {tag, " R4 idle after end"}, int'(pkt_valid), 0);
  endtask

  task automatic drain(string tag);
    do get_packet(tag);
    while (q_size(0) + q_size(1) + q_size(2) > 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      m_en[c] = 1'b0;
      m_rdov[c] = 1'b0;
    end
    m_isoe = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(!pkt_valid && !pkt_sop && !pkt_eop, "R1 stream idle", int'({pkt_valid, pkt_sop, pkt_eop}), 0);
    chk(!pkt_busy, "R1 not busy", int'(pkt_busy), 0);
    chk(pkt_data == 8'h00, "R1 data zero", int'(pkt_data), 0);
    get_packet("R1 reset packet");

    // R2: writes to disabled FIFOs are dropped
    for (int c = 0; c < 3; c++) write_byte(c, 8'h5A + 8'(c));
    get_packet("R2 disabled");

    // R3, R7, R8, R9: enable, then sweep fill levels and flag patterns
    for (int c = 0; c < 3; c++) enable_ch(c);
    for (int n = 0; n <= BD; n++) begin
      d_tx_stat  = 4'(n);
      b1_tx_stat = 3'(n) ^ 3'b101;
      b2_tx_stat = ~3'(n);
      for (int k = 0; k < n; k++)
        for (int c = 0; c < 3; c++)
          if (c != 0 || k < DD) write_byte(c, {2'(c), 6'(k)} ^ 8'(n * 7));
      drain($sformatf("R7 R8 R9 sweep n=%0d", n));
    end

    // R3: write in same cycle as enable is dropped; enable empties FIFO
    rx_en_cmd[1] = 1'b1;
    rx_wr_en[1] = 1'b1;
    rx_wr_data[15:8] = 8'hA5;
    @(negedge clk);
    rx_en_cmd[1] = 1'b0;
    rx_wr_en[1] = 1'b0;
    m_en[1] = 1'b1; m_rdov[1] = 1'b0; q_clear(1);
    get_packet("R3 enable with write");
    for (int k = 0; k < 3; k++) write_byte(2, 8'hC0 + 8'(k));
    enable_ch(2);
    get_packet("R3 enable empties");

    // R10: overflow on each channel, sticky flag, writes ignored, re-enable
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k <= depth(c); k++) write_byte(c, 8'(k + 16 * c));
      get_packet($sformatf("R10 overflow ch%0d", c));
      write_byte(c, 8'hEE);
      get_packet($sformatf("R10 sticky ch%0d", c));
      enable_ch(c);
      write_byte(c, 8'h3C);
      get_packet($sformatf("R10 recovered ch%0d", c));
    end

    // R5, R6: lead byte error flag
    out_crc_err = 1'b1; @(negedge clk); out_crc_err = 1'b0; m_isoe = 1'b1;
    get_packet("R5 R6 set");
    get_packet("R6 held");
    isoe_clear = 1'b1; @(negedge clk); isoe_clear = 1'b0; m_isoe = 1'b0;
    get_packet("R6 cleared");
    out_crc_err = 1'b1; isoe_clear = 1'b1; @(negedge clk);
    out_crc_err = 1'b0; isoe_clear = 1'b0; m_isoe = 1'b1;
    get_packet("R6 set wins");
    isoe_clear = 1'b1; @(negedge clk); isoe_clear = 1'b0; m_isoe = 1'b0;

    // R11: snapshot at acceptance
    d_tx_stat = 4'b1010; b1_tx_stat = 3'b011; b2_tx_stat = 3'b100;
    for (int k = 0; k < 5; k++) write_byte(0, 8'h70 + 8'(k));
    for (int k = 0; k < 3; k++) write_byte(2, 8'h90 + 8'(k));
    fork
      get_packet("R11 snapshot");
      begin
        repeat (2) @(negedge clk);
        d_tx_stat = 4'b0101; b1_tx_stat = 3'b110; b2_tx_stat = 3'b001;
        out_crc_err = 1'b1;
        @(negedge clk);
        out_crc_err = 1'b0;
        m_isoe = 1'b1;
        write_byte(2, 8'hB1);
        write_byte(2, 8'hB2);
      end
    join
    get_packet("R11 after change");

    // R12: request while busy is ignored
    for (int k = 0; k < 5; k++) write_byte(1, 8'h20 + 8'(k));
    fork
      get_packet("R12 first");
      begin
        repeat (3) @(negedge clk);
        chk(pkt_busy, "R12 busy during packet", int'(pkt_busy), 1);
        pkt_req = 1'b1;
        @(negedge clk);
        pkt_req = 1'b0;
      end
    join
    for (int k = 0; k < 8; k++) begin
      chk(!pkt_valid, "R12 no second packet", int'(pkt_valid), 0);
      @(negedge clk);
    end
    chk(!pkt_busy, "R12 idle", int'(pkt_busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule